// File: doc/BRIEF.md
# DDR SDRAM Mode Register Unit

This unit sits on the device side of a DDR SDRAM command bus. On every rising clock edge it samples the chip select, the row, column and write strobes, two bank-select bits and the twelve address lines. It recognises loads of the base mode register and of the extended mode register, and it stores the address word of each load that it accepts. From the base word it derives the burst length, the burst ordering, the read latency in half-cycle units, a test-mode level and a one-cycle DLL-reset pulse.

The unit also enforces the rules for a legal load. All banks must be idle. The clock enable must be high on the edge of the load and on the edge before it. The extended register must be loaded before the base register. A load needs two cycles to complete, and no other command may arrive in that time. A load that breaks one of these rules is rejected and flagged. A load carrying a reserved code is stored but raises a sticky flag.

Top module: `ddr_mode_reg_unit`

## Requirements
- R1: A load is a rising edge with `cs_ni`, `ras_ni`, `cas_ni` and `we_ni` all low. When `ba_i`=00 it targets the base register and when `ba_i`=01 it targets the extended register. When `ba_i[1]`=1 it is not a load. An accepted load stores `addr_i` whole, bits 11..9 included, in `mode_word_o` (base) or `ext_word_o` (extended) from the next cycle.
- R2: A load is accepted only if `banks_idle_i` is 1 and `cke_i` is 1 on that edge and on the previous edge. Otherwise the load is dropped, both words keep their values, and `load_err_o` is high for exactly the next cycle.
- R3: An accepted load drives `busy_o` high for the two cycles after its edge. Any command in that window is rejected, and `busy_viol_o` is high for the next cycle. A command here is `cs_ni` low with the three strobes not all high. This check takes priority over R2 and R5.
- R4: `programmed_o` is 0 from reset until the first accepted base load. While it is 0, every decoded output is 0.
- R5: A base load that arrives before any accepted extended load is rejected, and `order_err_o` is high for the next cycle.
- R6: The burst length comes from word bits 2..0. Code 001 gives 2, 010 gives 4 and 011 gives 8, shown as the value on `burst_len_o`. Every other code gives 0.
- R7: `interleave_o` follows word bit 3 (1 = interleaved). Code 111 with bit 3 = 0 sets `full_page_o`. Code 111 with bit 3 = 1 is reserved.
- R8: `cas_half_o` shows the latency in half cycles, from word bits 6..4. Code 010 gives 4, 011 gives 6, 100 gives 8 and 110 gives 5. Codes 000, 001, 101 and 111 give 0 and are reserved.
- R9: `test_mode_o` follows bit 7 of the stored base word.
- R10: An accepted base load with address bit 8 set drives `dll_reset_o` high for exactly one cycle. That cycle is the first cycle the new word is visible.
- R11: An accepted base load with a reserved burst or latency code still stores the word. It also sets `reserved_o`, which stays set until reset.
- R12: The base register can be reloaded any number of times while the banks are idle, and each legal reload replaces the decoded outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable level |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| ba_i | input | 2 | Register select bits |
| addr_i | input | 12 | Load data word |
| banks_idle_i | input | 1 | All banks precharged |
| mode_word_o | output | 12 | Stored base word |
| ext_word_o | output | 12 | Stored extended word |
| programmed_o | output | 1 | A base load has been accepted |
| busy_o | output | 1 | Completion window active |
| burst_len_o | output | 4 | Burst length (2, 4, 8 or 0) |
| full_page_o | output | 1 | Full-page sequential burst |
| interleave_o | output | 1 | Interleaved ordering |
| cas_half_o | output | 4 | Read latency in half cycles |
| test_mode_o | output | 1 | Test mode selected |
| dll_reset_o | output | 1 | One-cycle DLL reset request |
| reserved_o | output | 1 | Sticky reserved-code flag |
| load_err_o | output | 1 | Load rejected: banks busy or clock enable low |
| order_err_o | output | 1 | Base load rejected: extended register not yet loaded |
| busy_viol_o | output | 1 | Command issued during the busy window |

## Verification
A wrong stored word or a wrong extended-done bit shows up one cycle after the load. It appears on the word outputs, on the decoded fields or as a missing or extra order error. A miscounted busy window appears within three cycles, either as a busy level that is off by one cycle or as a violation flag on the wrong command. The reference model checks every output on every cycle. A fault in the clock-enable history or in the sticky flags is therefore reported on the first cycle it changes a port.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int unsigned BL_LSB  = 0;
  localparam int unsigned BT_BIT  = 3;
  localparam int unsigned CL_LSB  = 4;
  localparam int unsigned TM_BIT  = 7;
  localparam int unsigned DLL_BIT = 8;

  typedef struct packed {
    logic [3:0] burst_len;
    logic       full_page;
    logic       interleave;
    logic [3:0] cas_half;
    logic       reserved;
  } mrs_fields_t;
endpackage

// File: rtl/mrs_cmd_decode.sv
module mrs_cmd_decode (
  input  logic       cs_ni,
  input  logic       ras_ni,
  input  logic       cas_ni,
  input  logic       we_ni,
  input  logic [1:0] ba_i,
  output logic       cmd_o,
  output logic       base_ld_o,
  output logic       ext_ld_o
);
  logic all_low;

  assign all_low   = ~cs_ni & ~ras_ni & ~cas_ni & ~we_ni;
  assign cmd_o     = ~cs_ni & ~(ras_ni & cas_ni & we_ni);
  assign base_ld_o = all_low & (ba_i == 2'b00);
  assign ext_ld_o  = all_low & (ba_i == 2'b01);
endmodule

// File: rtl/mrs_field_decode.sv
module mrs_field_decode
  import mrs_pkg::*;
(
  input  logic [6:0]  word_i,
  output mrs_fields_t fields_o
);
  logic [2:0] bl_code;
  logic [2:0] cl_code;
  logic       bl_res;
  logic       cl_res;

  assign bl_code = word_i[BL_LSB +: 3];
  assign cl_code = word_i[CL_LSB +: 3];

  always_comb begin
    fields_o.burst_len  = 4'd0;
    fields_o.full_page  = 1'b0;
    fields_o.interleave = word_i[BT_BIT];
    bl_res              = 1'b0;
    unique case (bl_code)
      3'b001: fields_o.burst_len = 4'd2;
      3'b010: fields_o.burst_len = 4'd4;
      3'b011: fields_o.burst_len = 4'd8;
      3'b111: begin
        fields_o.full_page = ~word_i[BT_BIT];
        bl_res             = word_i[BT_BIT];
      end
      default: bl_res = 1'b1;
    endcase
  end

  always_comb begin
    fields_o.cas_half = 4'd0;
    cl_res            = 1'b0;
    unique case (cl_code)
      3'b010:  fields_o.cas_half = 4'd4;
      3'b011:  fields_o.cas_half = 4'd6;
      3'b100:  fields_o.cas_half = 4'd8;
      3'b110:  fields_o.cas_half = 4'd5;
      default: cl_res = 1'b1;
    endcase
  end

  assign fields_o.reserved = bl_res | cl_res;
endmodule

// File: rtl/ddr_mode_reg_unit.sv
module ddr_mode_reg_unit
  import mrs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BUSY_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              banks_idle_i,
  output logic [ADDR_W-1:0] mode_word_o,
  output logic [ADDR_W-1:0] ext_word_o,
  output logic              programmed_o,
  output logic              busy_o,
  output logic [3:0]        burst_len_o,
  output logic              full_page_o,
  output logic              interleave_o,
  output logic [3:0]        cas_half_o,
  output logic              test_mode_o,
  output logic              dll_reset_o,
  output logic              reserved_o,
  output logic              load_err_o,
  output logic              order_err_o,
  output logic              busy_viol_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

  logic              cmd, base_ld, ext_ld;
  logic              cke_q, ext_done_q, prog_q, res_q, dll_q;
  logic              lerr_q, oerr_q, berr_q;
  logic [CNT_W-1:0]  busy_q;
  logic [ADDR_W-1:0] word_q, ext_q;
  logic              busy, legal, viol, illegal, order_bad, acc_ext, acc_base;
  mrs_fields_t       in_f, st_f;

  mrs_cmd_decode u_cmd (
    .cs_ni    (cs_ni),
    .ras_ni   (ras_ni),
    .cas_ni   (cas_ni),
    .we_ni    (we_ni),
    .ba_i     (ba_i),
    .cmd_o    (cmd),
    .base_ld_o(base_ld),
    .ext_ld_o (ext_ld)
  );

  // one decoder screens the incoming word, one drives the outputs
  mrs_field_decode u_in_dec (.word_i(addr_i[6:0]), .fields_o(in_f));
  mrs_field_decode u_st_dec (.word_i(word_q[6:0]), .fields_o(st_f));

  assign busy      = (busy_q != '0);
  assign legal     = banks_idle_i & cke_i & cke_q;
  assign viol      = cmd & busy;
  assign illegal   = (base_ld | ext_ld) & ~busy & ~legal;
  assign order_bad = base_ld & ~busy & legal & ~ext_done_q;
  assign acc_ext   = ext_ld & ~busy & legal;
  assign acc_base  = base_ld & ~busy & legal & ext_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q      <= 1'b0;
      busy_q     <= '0;
      ext_done_q <= 1'b0;
      prog_q     <= 1'b0;
      res_q      <= 1'b0;
      dll_q      <= 1'b0;
      lerr_q     <= 1'b0;
      oerr_q     <= 1'b0;
      berr_q     <= 1'b0;
      word_q     <= '0;
      ext_q      <= '0;
    end else begin
      cke_q  <= cke_i;
      lerr_q <= illegal;
      oerr_q <= order_bad;
      berr_q <= viol;
      dll_q  <= acc_base & addr_i[DLL_BIT];
      if (acc_ext | acc_base) busy_q <= CNT_W'(BUSY_CYCLES);
      else if (busy)          busy_q <= busy_q - 1'b1;
      if (acc_ext) begin
        ext_q      <= addr_i;
        ext_done_q <= 1'b1;
      end
      if (acc_base) begin
        word_q <= addr_i;
        prog_q <= 1'b1;
        if (in_f.reserved) res_q <= 1'b1;
      end
    end
  end

  assign mode_word_o  = word_q;
  assign ext_word_o   = ext_q;
  assign programmed_o = prog_q;
  assign busy_o       = busy;
  assign burst_len_o  = prog_q ? st_f.burst_len : 4'd0;
  assign full_page_o  = prog_q & st_f.full_page;
  assign interleave_o = prog_q & st_f.interleave;
  assign cas_half_o   = prog_q ? st_f.cas_half : 4'd0;
  assign test_mode_o  = prog_q & word_q[TM_BIT];
  assign dll_reset_o  = dll_q;
  assign reserved_o   = res_q;
  assign load_err_o   = lerr_q;
  assign order_err_o  = oerr_q;
  assign busy_viol_o  = berr_q;
endmodule

// File: rtl/ddr_mode_reg_unit_chk.sv
module ddr_mode_reg_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       programmed_o,
  input logic       busy_o,
  input logic [3:0] burst_len_o,
  input logic [3:0] cas_half_o,
  input logic       dll_reset_o,
  input logic       reserved_o,
  input logic       load_err_o,
  input logic       order_err_o,
  input logic       busy_viol_o
);
  p_busy_two_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |=> !busy_o);
  p_busy_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);
  p_err_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_err_o, order_err_o, busy_viol_o}));
  p_prog_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    programmed_o |=> programmed_o);
  p_unprog_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !programmed_o |-> (burst_len_o == 4'd0) && (cas_half_o == 4'd0));
  p_prog_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(programmed_o) |-> busy_o);
  p_dll_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_reset_o |=> !dll_reset_o);
  p_dll_with_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_reset_o |-> busy_o && programmed_o);
  p_reserved_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reserved_o |=> reserved_o);
endmodule

bind ddr_mode_reg_unit ddr_mode_reg_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .programmed_o(programmed_o),
  .busy_o      (busy_o),
  .burst_len_o (burst_len_o),
  .cas_half_o  (cas_half_o),
  .dll_reset_o (dll_reset_o),
  .reserved_o  (reserved_o),
  .load_err_o  (load_err_o),
  .order_err_o (order_err_o),
  .busy_viol_o (busy_viol_o)
);

// File: tb/ddr_mode_reg_unit_tb_top.sv
`timescale 1ns/1ps
module ddr_mode_reg_unit_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'b00;
  logic [11:0] addr = '0;
  logic        idle = 1'b1;

  logic [11:0] mode_word, ext_word;
  logic        programmed, busy, full_page, interleave, test_mode, dll_reset;
  logic        reserved, load_err, order_err, busy_viol;
  logic [3:0]  burst_len, cas_half;

  ddr_mode_reg_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .banks_idle_i(idle),
    .mode_word_o(mode_word), .ext_word_o(ext_word), .programmed_o(programmed),
    .busy_o(busy), .burst_len_o(burst_len), .full_page_o(full_page),
    .interleave_o(interleave), .cas_half_o(cas_half), .test_mode_o(test_mode),
    .dll_reset_o(dll_reset), .reserved_o(reserved), .load_err_o(load_err),
    .order_err_o(order_err), .busy_viol_o(busy_viol)
  );

  int checks = 0, errors = 0;

  // reference model state
  int          m_busy, m_cke_prev, m_ext_done, m_prog, m_res, m_dll;
  int          m_lerr, m_oerr, m_berr;
  logic [11:0] m_word, m_ext;

  function automatic int exp_bl(logic [11:0] w);
    case (w[2:0])
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_cl(logic [11:0] w);
    case (w[6:4])
      3'd2: return 4;
      3'd3: return 6;
      3'd4: return 8;
      3'd6: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_res(logic [11:0] w);
    if (exp_cl(w) == 0) return 1;
    if (w[2:0] == 3'd7) return w[3] ? 1 : 0;
    return (exp_bl(w) == 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cke_prev = 0; m_ext_done = 0; m_prog = 0; m_res = 0;
      m_dll = 0; m_lerr = 0; m_oerr = 0; m_berr = 0; m_word = '0; m_ext = '0;
    end else begin
      automatic bit is_cmd  = !cs_n && !(ras_n && cas_n && we_n);
      automatic bit is_load = !cs_n && !ras_n && !cas_n && !we_n && !ba[1];
      automatic bit took = 0;
      m_dll = 0; m_lerr = 0; m_oerr = 0; m_berr = 0;
      if (is_cmd && m_busy > 0) m_berr = 1;
      else if (is_load) begin
        if (!idle || !cke || m_cke_prev == 0) m_lerr = 1;
        else if (ba == 2'b00 && m_ext_done == 0) m_oerr = 1;
        else begin
          took = 1;
          if (ba == 2'b01) begin m_ext = addr; m_ext_done = 1; end
          else begin
            m_word = addr; m_prog = 1; m_dll = addr[8];
            if (exp_res(addr) != 0) m_res = 1;
          end
        end
      end
      if (took) m_busy = 2;
      else if (m_busy > 0) m_busy = m_busy - 1;
      m_cke_prev = cke;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 mode_word", int'(mode_word), int'(m_word));
    chk("R1 ext_word", int'(ext_word), int'(m_ext));
    chk("R2 load_err", int'(load_err), m_lerr);
    chk("R3 busy", int'(busy), (m_busy > 0) ? 1 : 0);
    chk("R3 busy_viol", int'(busy_viol), m_berr);
    chk("R4 programmed", int'(programmed), m_prog);
    chk("R5 order_err", int'(order_err), m_oerr);
    chk("R6 burst_len", int'(burst_len), m_prog ? exp_bl(m_word) : 0);
    chk("R7 interleave", int'(interleave), m_prog ? int'(m_word[3]) : 0);
    chk("R7 full_page", int'(full_page),
        (m_prog != 0 && m_word[3:0] == 4'b0111) ? 1 : 0);
    chk("R8 cas_half", int'(cas_half), m_prog ? exp_cl(m_word) : 0);
    chk("R9 test_mode", int'(test_mode), m_prog ? int'(m_word[7]) : 0);
    chk("R10 dll_reset", int'(dll_reset), m_dll);
    chk("R11 reserved", int'(reserved), m_res);
  endtask

  task automatic step(bit c, bit r, bit ca, bit w, logic [1:0] b, logic [11:0] a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    @(negedge clk);
    compare_all();
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) step(1, 1, 1, 1, 2'b00, 12'h000);
  endtask

  task automatic load(logic [1:0] b, logic [11:0] a);
    step(0, 0, 0, 0, b, a);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all();                     // reset state, R4
    nop(2);
    load(2'b00, 12'h032); nop(3);      // R5 base before extended
    idle = 1'b0; load(2'b01, 12'h001); nop(2); idle = 1'b1;  // R2 banks busy
    cke = 1'b0; nop(1); cke = 1'b1;
    load(2'b01, 12'h002); nop(2);      // R2 clock enable low before
    load(2'b01, 12'h005);              // extended accepted
    load(2'b00, 12'h032); nop(3);      // R3 command inside window
    load(2'b00, 12'h032); nop(3);      // R6 R8 BL4 CL3
    chk("R8 latency 3", int'(cas_half), 6);
    load(2'b00, 12'hE6B); nop(3);      // R1 R7 R8 BL8 interleave 2.5, top bits
    chk("R8 latency 2.5", int'(cas_half), 5);
    load(2'b00, 12'h127); nop(3);      // R7 R10 full page, DLL reset
    chk("R7 full page", int'(full_page), 1);
    load(2'b10, 12'h0AA); nop(3);      // R1 ba=10 ignored
    chk("R1 ignored bank select", int'(mode_word), 12'h127);
    load(2'b00, 12'h0AF); nop(3);      // R9 R11 test mode, reserved BL
    chk("R11 reserved set", int'(reserved), 1);
    load(2'b00, 12'h022); nop(3);      // R12 reprogram, R11 stays
    chk("R12 reprogram", int'(burst_len), 4);
    chk("R11 reserved sticky", int'(reserved), 1);
    step(0, 1, 0, 1, 2'b00, 12'h000);  // read command outside window
    load(2'b00, 12'h052); step(0, 1, 0, 1, 2'b00, 0); nop(3);  // R3 read in window
    for (int i = 0; i < 3000; i++) begin
      idle = ($urandom_range(0, 9) != 0);
      cke  = ($urandom_range(0, 19) != 0);
      if ($urandom_range(0, 2) == 0)
        step(0, 0, 0, 0, 2'($urandom_range(0, 3)), 12'($urandom));
      else
        step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             2'($urandom), 12'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule